// File: doc/BRIEF.md
# Microprogram next-address sequencer

This block produces the control-memory address for a microprogrammed control unit. It keeps a 7-bit control address register, which is the address presented to the control memory, and a single return-address register used by subroutine calls. On every clock edge the register is reloaded from one of four places:

- the current address plus one;
- the branch target carried in the microinstruction;
- an address built from a 4-bit machine opcode;
- the saved return address.

The microinstruction fields that steer this choice come in as inputs. A 2-bit test selector picks a condition bit from the status inputs. A 2-bit branch kind says how that condition is used.

The control memory itself and the decoding of the microoperation fields are outside the block. The surrounding unit feeds the fields of the word it has just read, the opcode and the status bits. It reads the next address from `car`.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst` is high at a rising edge, `car` becomes START_ADDR (default 64) and the return register is cleared, so a return issued first after reset lands on address 0.
- R2: The tested condition T is selected by `cond_sel`:
  - 00 gives a constant 1.
  - 01 gives `ind_bit`.
  - 10 gives the top bit of `acc`.
  - 11 gives 1 exactly when `acc` is all zeros.
- R3: With `br_kind` = 00 (jump), `car` takes `jump_addr` when T is 1 and `car`+1 when T is 0.
- R4: With `br_kind` = 01 (call) and T = 1, `car` takes `jump_addr` and the return register takes the old `car`+1.
- R5: With `br_kind` = 01 and T = 0, `car` takes `car`+1 and the return register keeps its value.
- R6: With `br_kind` = 10 (return), `car` takes the return register's value whatever T is, and the return register is unchanged.
- R7: With `br_kind` = 11 (map), `car` takes the value built from three parts, whatever T is. The most significant bit is 0. The next four bits are `opcode`. The two least significant bits are 0. Opcode 15 therefore maps to 60.
- R8: The increment wraps modulo 128, so a non-branching step from address 127 gives 0.
- R9: The return register holds one level only: a second taken call overwrites the first return address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition selector field of the current microinstruction |
| br_kind | input | 2 | Branch kind field: 00 jump, 01 call, 10 return, 11 map |
| jump_addr | input | 7 | Branch target field of the current microinstruction |
| opcode | input | 4 | Operation code of the machine instruction being decoded |
| ind_bit | input | 1 | Indirect-addressing status bit |
| acc | input | 16 | Accumulator value used for the sign and zero tests |
| car | output | 7 | Control address register, the next control-memory address |

## Verification
Every cycle, the checker tests the four branch kinds against the port values of the previous cycle:
- for jumps and calls, the taken target and the incremented address;
- for calls, the saved return address;
- the return register stays stable whenever no taken call occurs;
- the return target and the mapped address.

Some behaviours only the bench scenarios can show:
- wrap-around from address 127;
- the cleared return register after reset;
- a second nested call overwriting the first return address;
- that a not-taken call leaves the saved address intact. The bench shows this by issuing a return after every vector and comparing the address it lands on.

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int AW = 7,
  parameter int OPW = 4,
  parameter int DW = 16,
  parameter int START_ADDR = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cond_sel,
  input  logic [1:0]    br_kind,
  input  logic [AW-1:0] jump_addr,
  input  logic [OPW-1:0] opcode,
  input  logic          ind_bit,
  input  logic [DW-1:0] acc,
  output logic [AW-1:0] car
);
  localparam int PADW = AW - 1 - OPW;

  logic [AW-1:0] sbr;
  logic [AW-1:0] car_inc;
  logic [AW-1:0] map_addr;
  logic [AW-1:0] car_nxt;
  logic          t_bit;
  logic          sel1, sel0, sbr_ld;

  always_comb begin
    case (cond_sel)
      2'd0: t_bit = 1'b1;
      2'd1: t_bit = ind_bit;
      2'd2: t_bit = acc[DW-1];
      default: t_bit = (acc == '0);
    endcase
  end

  assign sel1   = br_kind[1];
  assign sel0   = (~br_kind[1] & t_bit) | (br_kind[1] & br_kind[0]);
  assign sbr_ld = ~br_kind[1] & br_kind[0] & t_bit;

  assign car_inc  = car + AW'(1);
  assign map_addr = {1'b0, opcode, {PADW{1'b0}}};

  always_comb begin
    case ({sel1, sel0})
      2'b00: car_nxt = car_inc;
      2'b01: car_nxt = jump_addr;
      2'b10: car_nxt = sbr;
      default: car_nxt = map_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= AW'(START_ADDR);
      sbr <= '0;
    end else begin
      car <= car_nxt;
      if (sbr_ld) sbr <= car_inc;
    end
  end
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int AW = 7,
  parameter int OPW = 4,
  parameter int DW = 16,
  parameter int START_ADDR = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cond_sel,
  input logic [1:0]    br_kind,
  input logic [AW-1:0] jump_addr,
  input logic [OPW-1:0] opcode,
  input logic          ind_bit,
  input logic [DW-1:0] acc,
  input logic [AW-1:0] car,
  input logic [AW-1:0] sbr
);
  localparam int PADW = AW - 1 - OPW;

  logic tst;
  assign tst = (cond_sel == 2'd0) ? 1'b1 :
               (cond_sel == 2'd1) ? ind_bit :
               (cond_sel == 2'd2) ? acc[DW-1] : (acc == '0);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      AST_RESET_STATE: assert (car == AW'(START_ADDR) && sbr == '0); // R1
    end
  end

  AST_JMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b00 && tst) |=> car == $past(jump_addr)); // R3

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!br_kind[1] && !tst) |=> (car - $past(car)) == AW'(1)); // R5

  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b01 && tst) |=> (car == $past(jump_addr) && (sbr - $past(car)) == AW'(1))); // R4

  AST_SBR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(br_kind == 2'b01 && tst) |=> $stable(sbr)); // R9

  AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b10) |=> car == $past(sbr)); // R6

  AST_MAP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b11) |=> car == {1'b0, $past(opcode), {PADW{1'b0}}}); // R7
endmodule

bind useq_next_addr useq_next_addr_chk #(
  .AW(AW), .OPW(OPW), .DW(DW), .START_ADDR(START_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
  .jump_addr(jump_addr), .opcode(opcode), .ind_bit(ind_bit),
  .acc(acc), .car(car), .sbr(sbr)
);

// File: tb/useq_next_addr_test.sv
module useq_next_addr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cond_sel = '0;
  logic [1:0]  br_kind = '0;
  logic [6:0]  jump_addr = '0;
  logic [3:0]  opcode = '0;
  logic        ind_bit = 1'b0;
  logic [15:0] acc = '0;
  logic [6:0]  car;

  int checks = 0;
  int failures = 0;
  logic [6:0] m_car, m_sbr;

  useq_next_addr uut (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
    .jump_addr(jump_addr), .opcode(opcode), .ind_bit(ind_bit),
    .acc(acc), .car(car)
  );

  always #4 clk = ~clk;

  // row: {br_kind, cond_sel, source when T=0, source when T=1, save when T=1}
  // sources: 0 = car+1, 1 = jump_addr, 2 = mapped opcode, 3 = return register
  localparam logic [8:0] VEC [16] = '{
    {2'd0,2'd0,2'd0,2'd1,1'b0}, {2'd0,2'd1,2'd0,2'd1,1'b0},
    {2'd0,2'd2,2'd0,2'd1,1'b0}, {2'd0,2'd3,2'd0,2'd1,1'b0},
    {2'd1,2'd0,2'd0,2'd1,1'b1}, {2'd1,2'd1,2'd0,2'd1,1'b1},
    {2'd1,2'd2,2'd0,2'd1,1'b1}, {2'd1,2'd3,2'd0,2'd1,1'b1},
    {2'd2,2'd0,2'd3,2'd3,1'b0}, {2'd2,2'd1,2'd3,2'd3,1'b0},
    {2'd2,2'd2,2'd3,2'd3,1'b0}, {2'd2,2'd3,2'd3,2'd3,1'b0},
    {2'd3,2'd0,2'd2,2'd2,1'b0}, {2'd3,2'd1,2'd2,2'd2,1'b0},
    {2'd3,2'd2,2'd2,2'd2,1'b0}, {2'd3,2'd3,2'd2,2'd2,1'b0}
  };

  task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s car=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // Drive the status inputs so that the condition picked by cd equals t,
  // while the other conditions read the opposite value where possible.
  task automatic set_status(input logic [1:0] cd, input logic t);
    ind_bit = (cd == 2'd1) ? t : !t;
    case (cd)
      2'd2: acc = t ? 16'h8000 : 16'h0001;
      2'd3: acc = t ? 16'h0000 : 16'h8000;
      default: acc = t ? 16'h0001 : 16'h8000;
    endcase
  endtask

  task automatic step(input logic [1:0] br, input logic [1:0] cd, input logic t,
                      input logic [6:0] ad, input logic [3:0] op);
    br_kind = br; cond_sel = cd; jump_addr = ad; opcode = op;
    set_status(cd, t);
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    check("R1 reset address", car, 7'd64);
    step(2'd2, 2'd1, 1'b0, 7'd99, 4'd3);
    check("R1 return register cleared", car, 7'd0);
    m_car = 7'd0; m_sbr = 7'd0;

    for (int r = 0; r < 16; r++) begin
      for (int t = 0; t < 2; t++) begin
        logic [1:0] br, cd, src;
        logic [6:0] ad, exp;
        logic [3:0] op;
        br = VEC[r][8:7]; cd = VEC[r][6:5];
        if (cd == 2'd0 && t == 0) continue;
        src = (t == 1) ? VEC[r][2:1] : VEC[r][4:3];
        ad = 7'(r * 9 + t * 3 + 5);
        op = 4'(r + t * 7);
        case (src)
          2'd0: exp = m_car + 7'd1;
          2'd1: exp = ad;
          2'd2: exp = {1'b0, op, 2'b00};
          default: exp = m_sbr;
        endcase
        if (t == 1 && VEC[r][0]) m_sbr = m_car + 7'd1;
        m_car = exp;
        step(br, cd, 1'(t), ad, op);
        case (br)
          2'd0: check("R3 R2 jump", car, exp);
          2'd1: check(t == 1 ? "R4 R2 call taken" : "R5 R2 call not taken", car, exp);
          2'd2: check("R6 return", car, exp);
          default: check("R7 map", car, exp);
        endcase
        step(2'd2, 2'(r), 1'(r % 2), 7'd0, 4'd0);
        m_car = m_sbr;
        check("R5 R6 saved address via return", car, m_sbr);
      end
    end

    step(2'd0, 2'd0, 1'b1, 7'd127, 4'd0);
    check("R3 jump to top", car, 7'd127);
    step(2'd0, 2'd1, 1'b0, 7'd50, 4'd0);
    check("R8 wrap to zero", car, 7'd0);
    step(2'd3, 2'd2, 1'b0, 7'd9, 4'd15);
    check("R7 opcode 15", car, 7'd60);
    step(2'd3, 2'd3, 1'b1, 7'd9, 4'd0);
    check("R7 opcode 0", car, 7'd0);
    step(2'd0, 2'd0, 1'b1, 7'd10, 4'd0);
    step(2'd1, 2'd0, 1'b1, 7'd20, 4'd0);
    check("R4 first call", car, 7'd20);
    step(2'd1, 2'd3, 1'b1, 7'd30, 4'd0);
    check("R9 nested call", car, 7'd30);
    step(2'd2, 2'd0, 1'b1, 7'd0, 4'd0);
    check("R9 nested return overwrote", car, 7'd21);
    step(2'd1, 2'd2, 1'b0, 7'd90, 4'd0);
    check("R5 not taken call", car, 7'd22);
    step(2'd2, 2'd2, 1'b0, 7'd0, 4'd0);
    check("R5 return register kept", car, 7'd21);
    rst = 1'b1;
    step(2'd0, 2'd0, 1'b1, 7'd5, 4'd0);
    rst = 1'b0;
    check("R1 reset mid-run", car, 7'd64);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule